// File: doc/BRIEF.md
# Cascadable Segment Register Loader over I2C

This block is the receive side of a two-wire serial bus for a display driver that can be chained with copies of itself. A fast system clock oversamples the bus clock and data lines. The block finds start and stop conditions and accepts writes sent to one fixed 7-bit address. It answers by pulling the data line low through an open-drain enable. Every copy on the bus shares the address, so every copy takes the first byte after the address as its control byte. That byte holds a drive-mode bit, a bank bit and a 6-bit vector. The vector picks a device and one of its eight segment registers.

Each following byte goes to the segment register that the vector names. After each byte the vector moves on by two in direct mode, or by one in duplex mode. All copies advance their vectors together. Only the copy whose hardware subaddress matches the vector stores the byte and acknowledges it, so one long transfer can fill several chained devices one after another. The control byte and all eight segment registers go straight to the display output stage.

Top module: `segldr_top`

## Requirements
- R1: While reset is active and right after it, the control register and all eight segment registers read zero and the acknowledge enable `sdaOe` is low.
- R2: The first byte after a start is acknowledged only when it equals 0x74 (address 0111010, write bit 0). Any other first byte gets no acknowledge, and nothing is stored until the next start.
- R3: The byte after an accepted address is always acknowledged and stored whole in `ctrlReg`. Bit 7 is the bank, bit 6 is the mode (0 direct, 1 duplex) and bits 5..0 are the vector.
- R4: In direct mode a data byte is acknowledged and written to segment register vector[2:0] only when vector[5:3] equals `subAddr[2:0]`.
- R5: In duplex mode vector bit 5 and `subAddr[2]` are ignored. The device is selected when vector[4:3] equals `subAddr[1:0]`.
- R6: After each data byte the vector advances by 2 in direct mode and by 1 in duplex mode, modulo 64 (111111 wraps to 000000 in duplex; 111110 plus 2 gives 000000 in direct).
- R7: A data byte for a non-matching device is neither stored nor acknowledged, but the vector still advances.
- R8: A stop right after the control byte's acknowledge leaves every segment register unchanged. The new bank and mode still take effect.
- R9: A start arriving in the middle of a byte drops that byte without writing anything and begins address matching again.
- R10: `sdaOe` is raised only while the bus clock is low after the eighth bit, is held through the ninth clock, and is released once that clock falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as received |
| sdaIn | input | 1 | Bus data line as received |
| subAddr | input | 3 | Hardware subaddress of this device |
| sdaOe | output | 1 | 1 pulls the data line low (acknowledge) |
| ctrlReg | output | 8 | Control byte: bank, mode, vector |
| segRegs | output | 64 | Segment registers, register k at bits 8k+7..8k |

## Verification
Storing a data byte and advancing the vector happen in the same clock edge. The store must use the old vector and the control register must take the new one. Long data bursts with random control bytes and random subaddresses produce this case over and over, including bursts that cross the vector wrap and pass through other devices' address ranges. The bench judges each burst by comparing the acknowledge seen for every byte, the final vector and all eight registers with a bench model that places each byte at its pre-increment vector.

// File: rtl/segldr_pkg.sv
package segldr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_CTRL, PH_DATA} phase_e;

  // strobes from the bus sequencer to the register datapath
  typedef struct packed {
    logic       ctrlLoad;
    logic       dataLoad;
    logic [7:0] byteVal;
  } dpStrobe_t;
endpackage

// File: rtl/segldr_bus.sv
module segldr_bus
  import segldr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      devSel,
  output dpStrobe_t stb,
  output logic      sdaOe
);
  localparam int SW = SYNC_STAGES + 1;

  logic [SW-1:0] sclSync, sdaSync;
  logic scl, sclDly, sda, sdaDly;
  logic sclRise, sclFall, startSeen, stopSeen;
  phase_e phase, nextPhase;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic ackSlot, ackNow, commit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SW-2:0], sclIn};
      sdaSync <= {sdaSync[SW-2:0], sdaIn};
    end
  end

  assign scl    = sclSync[SW-2];
  assign sclDly = sclSync[SW-1];
  assign sda    = sdaSync[SW-2];
  assign sdaDly = sdaSync[SW-1];

  assign sclRise   = scl & ~sclDly;
  assign sclFall   = ~scl & sclDly;
  assign startSeen = scl & sclDly & sdaDly & ~sda;
  assign stopSeen  = scl & sclDly & ~sdaDly & sda;

  always_comb begin
    ackNow    = 1'b0;
    nextPhase = PH_IDLE;
    unique case (phase)
      PH_ADDR: begin
        ackNow    = (shReg == {DEV_ADDR, 1'b0});
        nextPhase = ackNow ? PH_CTRL : PH_IDLE;
      end
      PH_CTRL: begin
        ackNow    = 1'b1;
        nextPhase = PH_DATA;
      end
      PH_DATA: begin
        ackNow    = devSel;
        nextPhase = PH_DATA;
      end
      default: begin
        ackNow    = 1'b0;
        nextPhase = PH_IDLE;
      end
    endcase
  end

  assign commit = sclFall & ~ackSlot & (bitCnt == 4'd8) & (phase != PH_IDLE);

  always_comb begin
    stb.ctrlLoad = commit & (phase == PH_CTRL);
    stb.dataLoad = commit & (phase == PH_DATA);
    stb.byteVal  = shReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      shReg   <= '0;
      ackSlot <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (startSeen) begin
      phase   <= PH_ADDR;
      bitCnt  <= '0;
      ackSlot <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (stopSeen) begin
      phase   <= PH_IDLE;
      ackSlot <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (sclRise && !ackSlot && bitCnt < 4'd8) begin
        shReg  <= {shReg[6:0], sda};
        bitCnt <= bitCnt + 4'd1;
      end
      if (sclFall) begin
        if (ackSlot) begin
          ackSlot <= 1'b0;
          sdaOe   <= 1'b0;
          bitCnt  <= '0;
        end else if (bitCnt == 4'd8) begin
          ackSlot <= 1'b1;
          sdaOe   <= ackNow;
          phase   <= nextPhase;
        end
      end
    end
  end
endmodule

// File: rtl/segldr_regs.sv
module segldr_regs
  import segldr_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int SEG_W   = 8,
  parameter int VEC_W   = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                stb,
  input  logic [VEC_W-$clog2(NUM_SEG)-1:0] subAddr,
  output logic                     devSel,
  output logic [7:0]               ctrlReg,
  output logic [NUM_SEG*SEG_W-1:0] segRegs
);
  localparam int IDX_W = $clog2(NUM_SEG);
  localparam int SUB_W = VEC_W - IDX_W;
  localparam int MODE_BIT = 6;

  logic [VEC_W-1:0] vec, vecNext;
  logic [IDX_W-1:0] regIdx;
  logic [SUB_W-1:0] vecSub;
  logic duplex;

  assign vec    = ctrlReg[VEC_W-1:0];
  assign duplex = ctrlReg[MODE_BIT];
  assign regIdx = vec[IDX_W-1:0];
  assign vecSub = vec[VEC_W-1:IDX_W];

  // duplex ignores the top subaddress bit
  assign devSel = duplex ? (vecSub[SUB_W-2:0] == subAddr[SUB_W-2:0])
                         : (vecSub == subAddr);
  assign vecNext = vec + (duplex ? VEC_W'(1) : VEC_W'(2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ctrlReg <= '0;
    else if (stb.ctrlLoad) ctrlReg <= stb.byteVal;
    else if (stb.dataLoad) ctrlReg[VEC_W-1:0] <= vecNext;
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        segRegs[k*SEG_W +: SEG_W] <= '0;
      else if (stb.dataLoad && devSel && regIdx == IDX_W'(k))
        segRegs[k*SEG_W +: SEG_W] <= stb.byteVal[SEG_W-1:0];
    end
  end
endmodule

// File: rtl/segldr_top.sv
module segldr_top
  import segldr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  subAddr,
  output logic        sdaOe,
  output logic [7:0]  ctrlReg,
  output logic [63:0] segRegs
);
  dpStrobe_t stb;
  logic devSel;

  segldr_bus #(.DEV_ADDR(7'h3A), .SYNC_STAGES(2)) u_bus (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devSel(devSel), .stb(stb), .sdaOe(sdaOe)
  );

  segldr_regs #(.NUM_SEG(8), .SEG_W(8), .VEC_W(6)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .subAddr(subAddr),
    .devSel(devSel), .ctrlReg(ctrlReg), .segRegs(segRegs)
  );
endmodule

// File: rtl/segldr_chk.sv
module segldr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic [2:0]  subAddr,
  input logic        sdaOe,
  input logic [7:0]  ctrlReg,
  input logic [63:0] segRegs
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (ctrlReg == 8'h00 && segRegs == 64'h0 && !sdaOe));

  // R10
  ack_low_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  // R6
  vec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(segRegs) |-> ctrlReg[5:0] ==
      ($past(ctrlReg[5:0]) + ($past(ctrlReg[6]) ? 6'd1 : 6'd2)));

  // R4
  direct_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(segRegs) && !$past(ctrlReg[6])) |-> $past(ctrlReg[5:3]) == subAddr);

  // R5
  duplex_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(segRegs) && $past(ctrlReg[6])) |-> $past(ctrlReg[4:3]) == subAddr[1:0]);

  // R7
  store_needs_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(segRegs) |-> !$stable(ctrlReg[5:0]));
endmodule

bind segldr_top segldr_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .subAddr(subAddr),
  .sdaOe(sdaOe), .ctrlReg(ctrlReg), .segRegs(segRegs)
);

// File: tb/sim_segldr_top.sv
module sim_segldr_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] sub = 3'd0;
  logic sdaOe;
  logic [7:0] ctrlReg;
  logic [63:0] segRegs;
  logic sdaLine;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  logic [7:0] mCtrl;
  logic [7:0] mSeg [8];
  logic [7:0] dBuf [16];

  assign sdaLine = sdaM & ~sdaOe;

  always #2.5 clk = ~clk;

  segldr_top u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .subAddr(sub),
    .sdaOe(sdaOe), .ctrlReg(ctrlReg), .segRegs(segRegs)
  );

  task automatic waitH(int n = H);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit devMatch(logic [7:0] c, logic [2:0] s);
    if (c[6]) return c[4:3] == s[1:0];
    return c[5:3] == s;
  endfunction

  function automatic logic [5:0] stepVec(logic [7:0] c);
    return c[5:0] + (c[6] ? 6'd1 : 6'd2);
  endfunction

  task automatic busStart();
    sdaM = 1'b1; waitH();
    scl = 1'b1; waitH();
    sdaM = 1'b0; waitH();
    scl = 1'b0; waitH(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitH();
    scl = 1'b1; waitH();
    sdaM = 1'b1; waitH();
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitH();
      scl = 1'b1; waitH();
      scl = 1'b0; waitH(2);
    end
  endtask

  task automatic sendByte(logic [7:0] b, output bit ack);
    sendBits(b, 8);
    sdaM = 1'b1; waitH();
    scl = 1'b1; waitH(H / 2);
    ack = ~sdaLine;
    waitH(H / 2);
    scl = 1'b0; waitH(2);
  endtask

  task automatic compareRegs(string req);
    chk(ctrlReg == mCtrl, {req, " ctrl"}, ctrlReg, mCtrl);
    for (int k = 0; k < 8; k++)
      chk(segRegs[k*8 +: 8] == mSeg[k], {req, " seg"}, segRegs[k*8 +: 8], mSeg[k]);
  endtask

  // full write transfer, model updated per requirement; ends with stop unless noStop
  task automatic xfer(logic [7:0] addr, logic [7:0] ctl, int n, string req, bit noStop = 0);
    bit ack;
    busStart();
    sendByte(addr, ack);
    chk(ack == (addr == 8'h74), {req, " R2 address ack"}, ack, addr == 8'h74);
    if (addr != 8'h74) begin
      sendByte(ctl, ack);
      chk(!ack, {req, " R2 ignored byte"}, ack, 0);
      busStop();
      return;
    end
    sendByte(ctl, ack);
    chk(ack, {req, " R3 control ack"}, ack, 1);
    mCtrl = ctl;
    for (int i = 0; i < n; i++) begin
      bit exp;
      sendByte(dBuf[i], ack);
      exp = devMatch(mCtrl, sub);
      chk(ack == exp, {req, " R4/R5/R7 data ack"}, ack, exp);
      if (exp) mSeg[mCtrl[2:0]] = dBuf[i];
      mCtrl[5:0] = stepVec(mCtrl);
    end
    if (!noStop) begin
      busStop();
      chk(!sdaOe, {req, " R10 released"}, sdaOe, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mCtrl = 8'h00;
    for (int k = 0; k < 8; k++) mSeg[k] = 8'h00;
    waitH(4);
    // R1 during reset
    chk(ctrlReg == 0 && segRegs == 0 && !sdaOe, "R1 in reset", {ctrlReg, segRegs[55:0]}, 0);
    rstN = 1'b1;
    waitH(4);
    compareRegs("R1 after reset");

    // R3/R4 direct load of bank A on device 0
    sub = 3'd0;
    for (int i = 0; i < 4; i++) dBuf[i] = 8'hA0 + 8'(i);
    xfer(8'h74, 8'h00, 4, "R4");
    compareRegs("R4 direct bank A");

    // R2 wrong address and read bit
    xfer(8'h76, 8'h05, 0, "R2 wrong");
    xfer(8'h75, 8'h05, 0, "R2 read");
    compareRegs("R2 no change");

    // R8 bank switch with no data
    xfer(8'h74, 8'h81, 0, "R8");
    compareRegs("R8 bank only");

    // R6 wrap in direct mode, second byte falls to another device (R7)
    sub = 3'd7;
    dBuf[0] = 8'h5A; dBuf[1] = 8'hC3;
    xfer(8'h74, 8'h3E, 2, "R6");
    chk(ctrlReg[5:0] == 6'd2, "R6 direct wrap", ctrlReg[5:0], 2);
    compareRegs("R6/R7 wrap");

    // R6 duplex wrap 111111 -> 000000
    dBuf[0] = 8'h11; dBuf[1] = 8'h22;
    xfer(8'h74, 8'h7F, 2, "R6 duplex");
    chk(ctrlReg[5:0] == 6'd1, "R6 duplex wrap", ctrlReg[5:0], 1);
    compareRegs("R6 duplex");

    // R5 duplex ignores vector bit 5 against subAddr[2]
    sub = 3'b101;
    dBuf[0] = 8'h9C; dBuf[1] = 8'h3D;
    xfer(8'h74, 8'h48, 2, "R5");
    compareRegs("R5 duplex select");

    // R9 repeated start in mid-byte drops the byte
    dBuf[0] = 8'hE7;
    xfer(8'h74, 8'h4B, 1, "R9", 1);
    sendBits(8'hFF, 4);
    dBuf[0] = 8'h66;
    xfer(8'h74, 8'h4C, 1, "R9 restart");
    compareRegs("R9 abort");

    // constrained random bursts
    for (int t = 0; t < 40; t++) begin
      int n;
      logic [7:0] a;
      if (t % 5 == 0) sub = 3'($urandom);
      n = $urandom % 10;
      for (int i = 0; i < n; i++) dBuf[i] = 8'($urandom);
      a = ($urandom % 8 == 0) ? 8'($urandom) : 8'h74;
      xfer(a, 8'($urandom), n, "R6 random");
      compareRegs("R4/R5/R7 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule